// File: doc/BRIEF.md
# Two-Output Action-Qualified PWM Generator

A 16-bit up-counting time base runs from a prescaled clock and drives two PWM outputs, A and B. Both outputs share one period value; each has its own compare value and its own 6-bit action word. The action word says what the output does on three events: the counter sitting at zero, at the period value, or at the output's compare value. Each event can leave the output alone, force it low, force it high or toggle it. A period value of P gives a cycle of P+1 prescaled ticks.

A simple write port loads a control word, the period, the two compare values and the two action words. New period values are written to a shadow register and reach the counter only when it wraps back to zero, so a running waveform never sees a truncated cycle. Compare values and action words take effect at once. Full duty is obtained by giving the compare event no action, which avoids needing a compare value one past the largest period.

Top module: `pwm2ch_aq`

## Requirements
- R1: While running, the counter steps by one on each prescaled tick from 0 up to the active period P, then returns to 0 on the next tick, so one cycle is P+1 ticks long.
- R2: Action words hold 2-bit codes: bits [1:0] for the zero event, bits [3:2] for the period event, bits [5:4] for the compare event; code 00 leaves the output, 01 drives it low, 10 drives it high, 11 toggles it. On each tick the output takes the result of the events matched by the counter value being left at that tick.
- R3: When several events match on one tick they apply in the order zero, period, compare, so the compare action has the last word; with zero-high and compare-low, a compare value of 0 gives an output that stays low.
- R4: Output A uses compare A and action word A, output B uses compare B and action word B, and both follow the one shared counter; with zero-high and compare-low, a compare value C gives C high ticks per cycle.
- R5: A period write while running takes effect only when the counter wraps to zero; the cycle in progress completes with the old period.
- R6: The tick rate is the system clock divided by 2^F times S, where F is the first 3-bit prescaler code and S is 1 for a second code of 0 or twice the code otherwise.
- R7: A compare action of 00, or a compare value above the period, never ends the level set by the zero event, giving 100% duty with zero-high.
- R8: With the run bit clear the counter is held at zero, the outputs keep their level, and a written period becomes active directly.
- R9: After reset both outputs are low, the counter is zero and all registers are zero.
- R10: Write addresses: 0 control (bit 0 run, bits [3:1] first prescaler code, bits [6:4] second prescaler code), 1 period, 2 compare A, 3 compare B, 4 action word A, 5 action word B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | CW | Write data |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |

## Verification
A wrong counter limit or a lost shadow load shows as a wrong distance between rising edges of an output within one or two PWM cycles, so the bench measures edge-to-edge period and high time on each output. A wrong event order or action decode shows as a wrong high time or a stuck level in the first cycle after start. A prescaler fault scales every measured interval by the wrong factor, visible in the first full cycle.

// File: rtl/pwm2ch_aq.sv
module pwm2ch_aq #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          pwm_a,
  output logic          pwm_b
);
  localparam int PW = 11;

  logic          run;
  logic [2:0]    cdiv, hdiv;
  logic [CW-1:0] prd_sh, prd_act, cmp_a, cmp_b, cnt;
  logic [5:0]    aq_a, aq_b;
  logic [PW-1:0] pc, div;
  logic [3:0]    hs;
  logic          tick, wrap, na, nb;

  assign hs   = (hdiv == 3'd0) ? 4'd1 : {hdiv, 1'b0};
  assign div  = {{(PW-4){1'b0}}, hs} << cdiv;
  assign tick = run && (pc >= div - 1'b1);
  assign wrap = (cnt == prd_act);

  function automatic logic act(input logic cur, input logic [1:0] code);
    case (code)
      2'b01:   act = 1'b0;
      2'b10:   act = 1'b1;
      2'b11:   act = ~cur;
      default: act = cur;
    endcase
  endfunction

  function automatic logic step(input logic cur, input logic [5:0] aq,
                                input logic z, input logic p, input logic c);
    logic o;
    o = cur;
    if (z) o = act(o, aq[1:0]);
    if (p) o = act(o, aq[3:2]);
    if (c) o = act(o, aq[5:4]);
    step = o;
  endfunction

  assign na = step(pwm_a, aq_a, cnt == '0, wrap, cnt == cmp_a);
  assign nb = step(pwm_b, aq_b, cnt == '0, wrap, cnt == cmp_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; cdiv <= '0; hdiv <= '0;
      prd_sh <= '0; prd_act <= '0; cmp_a <= '0; cmp_b <= '0;
      aq_a <= '0; aq_b <= '0; pc <= '0; cnt <= '0;
      pwm_a <= 1'b0; pwm_b <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          3'd0: {hdiv, cdiv, run} <= wr_data[6:0];
          3'd1: prd_sh <= wr_data;
          3'd2: cmp_a  <= wr_data;
          3'd3: cmp_b  <= wr_data;
          3'd4: aq_a   <= wr_data[5:0];
          3'd5: aq_b   <= wr_data[5:0];
          default: ;
        endcase
      end
      pc <= (!run || tick) ? '0 : pc + 1'b1;
      if (!run)
        cnt <= '0;
      else if (tick)
        cnt <= wrap ? '0 : cnt + 1'b1;
      if (!run || (tick && wrap))
        prd_act <= prd_sh;
      if (tick) begin
        pwm_a <= na;
        pwm_b <= nb;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= prd_act); // R1
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == prd_act) |=> cnt == '0); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt != prd_act) |=> cnt == $past(cnt) + 1'b1); // R1
  AST_CMP_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == cmp_a && aq_a[5:4] == 2'b01) |=> !pwm_a); // R3
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !(tick && cnt == prd_act)) |=> $stable(prd_act)); // R5
  AST_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> ($stable(cnt) && $stable(pwm_a) && $stable(pwm_b))); // R6
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0 && $stable(pwm_a) && $stable(pwm_b))); // R8
endmodule

// File: tb/sim_pwm2ch_aq.sv
`timescale 1ns/1ps
module sim_pwm2ch_aq;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic pwm_a, pwm_b;
  int total = 0, bad = 0;
  bit done = 0;

  pwm2ch_aq #(.CW(16)) u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                           .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b));

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1; wr_addr = a[2:0]; wr_data = d[15:0];
    @(negedge clk); wr_en = 0;
  endtask

  function automatic logic smp(input bit ch);
    return ch ? pwm_b : pwm_a;
  endfunction

  task automatic wait_rise(input bit ch, output int n);
    logic prev, s;
    prev = smp(ch); n = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk); n++; s = smp(ch);
      if (s && !prev) return;
      prev = s;
    end
  endtask

  task automatic measure(input bit ch, output int per, output int hi);
    int n; logic prev, s;
    wait_rise(ch, n);
    per = 1; hi = 1; prev = 1;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk); s = smp(ch);
      if (s && !prev) return;
      per++; if (s) hi++;
      prev = s;
    end
  endtask

  task automatic setup(input int ctrl, input int prd, input int ca, input int aa,
                       input int cb, input int ab);
    wr(0, 0); wr(1, prd); wr(2, ca); wr(4, aa); wr(3, cb); wr(5, ab); wr(0, ctrl);
  endtask

  task automatic hold_level(input bit ch, input logic lvl, input string tag);
    int errs = 0;
    repeat (20) @(negedge clk);
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (smp(ch) !== lvl) errs++; end
    check(errs == 0, tag, errs, 0);
  endtask

  task automatic t_reset;
    check(pwm_a === 1'b0, "R9 reset pwm_a", pwm_a, 0);
    check(pwm_b === 1'b0, "R9 reset pwm_b", pwm_b, 0);
  endtask

  task automatic t_basic;
    int p, h;
    setup(1, 9, 3, 'h12, 7, 'h12);
    measure(0, p, h);
    check(p == 10, "R1 period A", p, 10);
    check(h == 3, "R4 high A", h, 3);
    measure(1, p, h);
    check(h == 7, "R4 high B", h, 7);
    check(p == 10, "R4 shared period B", p, 10);
  endtask

  task automatic t_invert;
    int p, h;
    setup(1, 9, 3, 'h21, 0, 0);
    measure(0, p, h);
    check(h == 7, "R2 inverted high", h, 7);
  endtask

  task automatic t_toggle;
    int p, h;
    setup(1, 4, 0, 'h03, 0, 0);
    measure(0, p, h);
    check(p == 10 && h == 5, "R2 toggle period", p, 10);
  endtask

  task automatic t_prdact;
    int p, h;
    setup(1, 9, 0, 'h06, 0, 0);
    measure(0, p, h);
    check(h == 9, "R2 period event low", h, 9);
  endtask

  task automatic t_full;
    setup(1, 9, 3, 'h02, 0, 0);
    hold_level(0, 1'b1, "R7 no compare action full duty");
    setup(1, 9, 50, 'h12, 0, 0);
    hold_level(0, 1'b1, "R7 compare above period");
    setup(1, 9, 0, 'h12, 0, 0);
    hold_level(0, 1'b0, "R3 compare zero after zero event");
  endtask

  task automatic t_prescale;
    int p, h;
    setup('h33, 4, 2, 'h12, 0, 0);
    measure(0, p, h);
    check(p == 60, "R6 period div12", p, 60);
    check(h == 24, "R6 high div12", h, 24);
    setup('h07, 3, 1, 'h12, 0, 0);
    measure(0, p, h);
    check(p == 32 && h == 8, "R6 period div8", p, 32);
  endtask

  task automatic t_shadow;
    int n, p, h;
    setup(1, 9, 3, 'h12, 0, 0);
    wait_rise(0, n);
    repeat (2) @(negedge clk);
    wr_en = 1; wr_addr = 3'd1; wr_data = 16'd19;
    @(negedge clk); wr_en = 0;
    wait_rise(0, n);
    check(n == 7, "R5 old period completes", n + 3, 10);
    measure(0, p, h);
    check(p == 20, "R5 new period after wrap", p, 20);
  endtask

  task automatic t_stop;
    int n, p, h;
    setup(1, 9, 3, 'h12, 0, 0);
    wait_rise(0, n);
    wr_en = 1; wr_addr = 3'd0; wr_data = 16'd0;
    @(negedge clk); wr_en = 0;
    hold_level(0, 1'b1, "R8 stopped output holds");
    wr(1, 4); wr(0, 1);
    measure(0, p, h);
    check(p == 5, "R8 direct period while stopped", p, 5);
    check(h == 3, "R10 compare address", h, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic(); t_invert(); t_toggle(); t_prdact(); t_full();
    t_prescale(); t_shadow(); t_stop();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule